// File: doc/BRIEF.md
# Pulse-and-Verify Word Programming Sequencer

This block is the programmer-side controller for a one-time-programmable memory target. The target receives data on a parallel bus, programs while a strobe line is held low, and moves its own address counter on one high-then-low cycle of a step line. For each word the host presents, the sequencer drives the data bus and the strobe. After every program pulse it releases the bus and issues a short verify pulse, then compares the read-back with the intended word. It retries until the read-back matches or an attempt limit is reached.

When the first verify passes after N pulses, the sequencer adds A·N+B margin pulses with no verify between them. It then steps the target to the next location and reports done with N. If the word still mismatches when the limit is reached, it reports failure and does not step. A word flagged as the configuration word follows a different rule. It gets a series of pulses, with no verify between them, until their summed width reaches a fixed total. One verify follows the series. All times are whole microseconds, turned into clock cycles through the `CLK_HZ` parameter.

The settings (pulse width, attempt limit, A, B) are inputs and are sampled when a job starts. Typical values are a 100 µs pulse, a limit of 8, A = 11 and B = 0.

Top module: `pvs_prog_seq`

## Requirements
- R1: In reset and right after it: `tgt_strobe_n_o`=1, `tgt_step_o`=0, `tgt_oe_o`=0, `busy_o`=0, `done_o`=0, `fail_o`=0.
- R2: A program pulse holds `tgt_strobe_n_o` low for `pulse_us_i`·CPU cycles, where CPU = CLK_HZ/10^6. `tgt_dat_o` equals the job's word throughout. `tgt_oe_o` stays high in one unbroken run of (TSU_US + `pulse_us_i` + TH_US)·CPU cycles around the pulse.
- R3: A verify pulse holds `tgt_strobe_n_o` low for TVER_US·CPU cycles with `tgt_oe_o`=0. The read-back is taken in its last low cycle. Any two low periods are separated by at least TREC_US·CPU high cycles.
- R4: For an ordinary word, every program pulse is followed by exactly one verify. Pulses repeat until `tgt_dat_i` equals the word. `pulses_o` then holds the number N of pulses needed.
- R5: If the verify still mismatches after L pulses, the job ends with `done_o` and `fail_o`=1, `pulses_o`=L and no step cycle. L is `max_tries_i`, and a value of 0 counts as 1.
- R6: A match seen at the verify of pulse number L counts as a pass, not a failure.
- R7: After a pass with N pulses, `over_a_i`·N+`over_b_i` further program pulses follow with no verify. When that count is 0, the step follows at once.
- R8: A successful word ends with exactly one step cycle: `tgt_step_o` high for TINC_US·CPU cycles while `tgt_strobe_n_o` is high, then low for the same time, then `done_o`.
- R9: With `cfg_word_i`=1, P = ceil(CFG_TOTAL_US/`pulse_us_i`) program pulses follow one another with no verify. One verify comes after them. `pulses_o`=P. A match steps the target, and a mismatch sets `fail_o`.
- R10: `start_i` and `word_i` are ignored while `busy_o` is high.
- R11: `busy_o` is high from the cycle after `start_i` until `done_o`. `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a job for the presented word (idle only) |
| word_i | input | DW | Word to program |
| cfg_word_i | input | 1 | Word is the configuration word (fixed-total pulse rule) |
| pulse_us_i | input | PW_W | Program pulse width in µs |
| max_tries_i | input | CNT_W | Attempt limit L (0 acts as 1) |
| over_a_i | input | CO_W | Margin coefficient A |
| over_b_i | input | CO_W | Margin offset B |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |
| fail_o | output | 1 | Last job failed; held until next start |
| pulses_o | output | CNT_W | Pulse count N (or P, or L) of the last job |
| tgt_strobe_n_o | output | 1 | Target strobe, low = pulse |
| tgt_step_o | output | 1 | Target address step line |
| tgt_oe_o | output | 1 | Bus drive enable (0 = released) |
| tgt_dat_o | output | DW | Bus data driven to target |
| tgt_dat_i | input | DW | Bus data read back from target |

## Verification
Two events can coincide in the decision cycle that follows the verify of pulse L: the read-back match and the attempt-limit condition. The correct result is a pass. The bench's target model accepts the word only after a chosen number of pulses. A sweep of that number across and just past L lands the first match exactly on the limit. The result is judged by `fail_o`, `pulses_o`, the count of margin pulses and the presence of exactly one step cycle. A second coincidence occurs when a new start arrives in the middle of a job. The bench asserts it with a different word, and the data checked on every later program pulse shows that the new start was ignored.

// File: rtl/pvs_pkg.sv
package pvs_pkg;

  typedef enum logic [1:0] {OP_PROG, OP_VERIFY, OP_STEP} op_e;

  // Cycles-minus-one to load into a down counter for a phase of `us` microseconds.
  function automatic logic [31:0] phase_load(input int unsigned us, input int unsigned cpu);
    int unsigned cyc;
    cyc = us * cpu;
    return (cyc == 0) ? 32'd0 : 32'(cyc - 1);
  endfunction

  // Margin pulses after a pass that needed n pulses.
  function automatic logic [31:0] extra_pulses(input int unsigned a, input int unsigned n,
                                               input int unsigned b);
    return 32'(a * n + b);
  endfunction

endpackage

// File: rtl/pvs_phase_engine.sv
module pvs_phase_engine #(
  parameter int unsigned CPU     = 1,
  parameter int unsigned TSU_US  = 1,
  parameter int unsigned TH_US   = 1,
  parameter int unsigned TREC_US = 10,
  parameter int unsigned TVER_US = 1,
  parameter int unsigned TINC_US = 1,
  parameter int unsigned DW      = 12,
  parameter int unsigned PW_W    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_i,
  input  pvs_pkg::op_e    op_i,
  input  logic [PW_W-1:0] pw_us_i,
  input  logic [DW-1:0]   data_i,
  output logic            strobe_n_o,
  output logic            inc_o,
  output logic            oe_o,
  output logic [DW-1:0]   dat_o,
  output logic            idle_o,
  output logic            fin_o,
  output logic            smp_o
);
  import pvs_pkg::*;

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HOLD, PH_REC, PH_INCH, PH_INCL} ph_e;

  ph_e              ph;
  op_e              op_q;
  logic [31:0]      tmr;
  logic [PW_W-1:0]  pw_q;
  logic [DW-1:0]    dat_q;
  logic             tmr_end;

  assign tmr_end = (tmr == 32'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      op_q  <= OP_PROG;
      tmr   <= 32'd0;
      pw_q  <= '0;
      dat_q <= '0;
    end else if (ph == PH_IDLE) begin
      if (go_i) begin
        op_q <= op_i;
        pw_q <= pw_us_i;
        unique case (op_i)
          OP_PROG: begin
            dat_q <= data_i;
            ph    <= PH_SETUP;
            tmr   <= phase_load(TSU_US, CPU);
          end
          OP_VERIFY: begin
            ph  <= PH_LOW;
            tmr <= phase_load(TVER_US, CPU);
          end
          default: begin
            ph  <= PH_INCH;
            tmr <= phase_load(TINC_US, CPU);
          end
        endcase
      end
    end else if (!tmr_end) begin
      tmr <= tmr - 32'd1;
    end else begin
      unique case (ph)
        PH_SETUP: begin ph <= PH_LOW; tmr <= phase_load(32'(pw_q), CPU); end
        PH_LOW: begin
          if (op_q == OP_PROG) begin ph <= PH_HOLD; tmr <= phase_load(TH_US, CPU); end
          else begin ph <= PH_REC; tmr <= phase_load(TREC_US, CPU); end
        end
        PH_HOLD:  begin ph <= PH_REC;  tmr <= phase_load(TREC_US, CPU); end
        PH_INCH:  begin ph <= PH_INCL; tmr <= phase_load(TINC_US, CPU); end
        default:  ph <= PH_IDLE;  // PH_REC, PH_INCL
      endcase
    end
  end

  assign strobe_n_o = (ph != PH_LOW);
  assign inc_o      = (ph == PH_INCH);
  assign oe_o       = (op_q == OP_PROG) && (ph == PH_SETUP || ph == PH_LOW || ph == PH_HOLD);
  assign dat_o      = dat_q;
  assign idle_o     = (ph == PH_IDLE);
  assign fin_o      = tmr_end && (ph == PH_REC || ph == PH_INCL);
  assign smp_o      = tmr_end && (ph == PH_LOW) && (op_q == OP_VERIFY);

  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && $past(oe_o)) |-> $stable(dat_o)); // R2
  AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> (ph == PH_IDLE)); // R3

endmodule

// File: rtl/pvs_seq_ctrl.sv
module pvs_seq_ctrl #(
  parameter int unsigned DW           = 12,
  parameter int unsigned PW_W         = 16,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned CO_W         = 8,
  parameter int unsigned CFG_TOTAL_US = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DW-1:0]    word_i,
  input  logic             cfg_i,
  input  logic [PW_W-1:0]  pw_us_i,
  input  logic [CNT_W-1:0] max_att_i,
  input  logic [CO_W-1:0]  coef_a_i,
  input  logic [CO_W-1:0]  coef_b_i,
  input  logic             fin_i,
  input  logic             smp_i,
  input  logic [DW-1:0]    rd_i,
  output logic             go_o,
  output pvs_pkg::op_e     op_o,
  output logic [DW-1:0]    word_o,
  output logic [PW_W-1:0]  pw_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [CNT_W-1:0] n_o
);
  import pvs_pkg::*;

  typedef enum logic [2:0] {C_IDLE, C_PROGW, C_VERW, C_OVRW, C_STEPW} cs_e;

  cs_e              cs;
  logic [DW-1:0]    word_q;
  logic             cfg_q;
  logic [PW_W-1:0]  pw_q;
  logic [CNT_W-1:0] lim_q;
  logic [CO_W-1:0]  a_q, b_q;
  logic [CNT_W-1:0] att;
  logic [31:0]      left, acc, acc_nx, extra_w;
  logic             match_q, go_q, done_q, fail_q;
  op_e              op_q;

  // Named internal events for the checks below.
  logic limit_hit, cfg_full;
  assign limit_hit = (att >= lim_q);
  assign acc_nx    = acc + 32'(pw_q);
  assign cfg_full  = (acc_nx >= 32'(CFG_TOTAL_US));
  assign extra_w   = extra_pulses(32'(a_q), 32'(att), 32'(b_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs <= C_IDLE; word_q <= '0; cfg_q <= 1'b0; pw_q <= '0; lim_q <= '0;
      a_q <= '0; b_q <= '0; att <= '0; left <= '0; acc <= '0;
      match_q <= 1'b0; go_q <= 1'b0; done_q <= 1'b0; fail_q <= 1'b0; op_q <= OP_PROG;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      unique case (cs)
        C_IDLE: if (start_i) begin
          word_q  <= word_i;
          cfg_q   <= cfg_i;
          pw_q    <= pw_us_i;
          lim_q   <= (max_att_i == '0) ? CNT_W'(1) : max_att_i;
          a_q     <= coef_a_i;
          b_q     <= coef_b_i;
          att     <= '0;
          acc     <= '0;
          fail_q  <= 1'b0;
          match_q <= 1'b0;
          go_q    <= 1'b1;
          op_q    <= OP_PROG;
          cs      <= C_PROGW;
        end
        C_PROGW: if (fin_i) begin
          att  <= att + 1'b1;
          go_q <= 1'b1;
          if (!cfg_q) begin
            op_q <= OP_VERIFY; cs <= C_VERW;
          end else begin
            acc <= acc_nx;
            if (cfg_full) begin op_q <= OP_VERIFY; cs <= C_VERW; end
            else op_q <= OP_PROG;
          end
        end
        C_VERW: begin
          if (smp_i) match_q <= (rd_i == word_q);
          if (fin_i) begin
            if (match_q) begin
              go_q <= 1'b1;
              if (cfg_q || extra_w == 32'd0) begin op_q <= OP_STEP; cs <= C_STEPW; end
              else begin left <= extra_w; op_q <= OP_PROG; cs <= C_OVRW; end
            end else if (cfg_q || limit_hit) begin
              done_q <= 1'b1; fail_q <= 1'b1; cs <= C_IDLE;
            end else begin
              go_q <= 1'b1; op_q <= OP_PROG; cs <= C_PROGW;
            end
          end
        end
        C_OVRW: if (fin_i) begin
          go_q <= 1'b1;
          if (left == 32'd1) begin op_q <= OP_STEP; cs <= C_STEPW; end
          else begin left <= left - 32'd1; op_q <= OP_PROG; end
        end
        default: if (fin_i) begin  // C_STEPW
          done_q <= 1'b1; fail_q <= 1'b0; cs <= C_IDLE;
        end
      endcase
    end
  end

  assign go_o   = go_q;
  assign op_o   = op_q;
  assign word_o = word_q;
  assign pw_o   = pw_q;
  assign busy_o = (cs != C_IDLE);
  assign done_o = done_q;
  assign fail_o = fail_q;
  assign n_o    = att;

  AST_SMP_IN_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
    smp_i |-> (cs == C_VERW)); // R3
  AST_FIN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fin_i |-> (cs != C_IDLE)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(word_q)); // R10
  AST_ATT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cfg_q) |-> (att <= lim_q)); // R5
  AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fail_o && !cfg_q) |-> (n_o == lim_q)); // R5

endmodule

// File: rtl/pvs_prog_seq.sv
module pvs_prog_seq #(
  parameter int unsigned CLK_HZ       = 10_000_000,
  parameter int unsigned DW           = 12,
  parameter int unsigned PW_W         = 16,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned CO_W         = 8,
  parameter int unsigned TSU_US       = 1,
  parameter int unsigned TH_US        = 1,
  parameter int unsigned TREC_US      = 10,
  parameter int unsigned TVER_US      = 1,
  parameter int unsigned TINC_US      = 1,
  parameter int unsigned CFG_TOTAL_US = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DW-1:0]    word_i,
  input  logic             cfg_word_i,
  input  logic [PW_W-1:0]  pulse_us_i,
  input  logic [CNT_W-1:0] max_tries_i,
  input  logic [CO_W-1:0]  over_a_i,
  input  logic [CO_W-1:0]  over_b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fail_o,
  output logic [CNT_W-1:0] pulses_o,
  output logic             tgt_strobe_n_o,
  output logic             tgt_step_o,
  output logic             tgt_oe_o,
  output logic [DW-1:0]    tgt_dat_o,
  input  logic [DW-1:0]    tgt_dat_i
);
  localparam int unsigned CPU = (CLK_HZ / 1_000_000 == 0) ? 1 : CLK_HZ / 1_000_000;

  logic            go, eng_idle, fin, smp;
  pvs_pkg::op_e    op;
  logic [DW-1:0]   word_q;
  logic [PW_W-1:0] pw_q;

  pvs_seq_ctrl #(
    .DW(DW), .PW_W(PW_W), .CNT_W(CNT_W), .CO_W(CO_W), .CFG_TOTAL_US(CFG_TOTAL_US)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i), .cfg_i(cfg_word_i),
    .pw_us_i(pulse_us_i), .max_att_i(max_tries_i), .coef_a_i(over_a_i), .coef_b_i(over_b_i),
    .fin_i(fin), .smp_i(smp), .rd_i(tgt_dat_i),
    .go_o(go), .op_o(op), .word_o(word_q), .pw_o(pw_q),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .n_o(pulses_o)
  );

  pvs_phase_engine #(
    .CPU(CPU), .TSU_US(TSU_US), .TH_US(TH_US), .TREC_US(TREC_US),
    .TVER_US(TVER_US), .TINC_US(TINC_US), .DW(DW), .PW_W(PW_W)
  ) eng_i (
    .clk(clk), .rst_n(rst_n), .go_i(go), .op_i(op), .pw_us_i(pw_q), .data_i(word_q),
    .strobe_n_o(tgt_strobe_n_o), .inc_o(tgt_step_o), .oe_o(tgt_oe_o), .dat_o(tgt_dat_o),
    .idle_o(eng_idle), .fin_o(fin), .smp_o(smp)
  );

  AST_IDLE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> eng_idle); // R11
  AST_STEP_STROBE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_step_o) |-> $past(tgt_strobe_n_o)); // R8

endmodule

// File: tb/pvs_prog_seq_tb_top.sv
module pvs_prog_seq_tb_top;
  localparam int CLK_HZ = 2_000_000;
  localparam int CPU    = 2;
  localparam int TSU = 1, TH = 1, TREC = 10, TVER = 1, TINC = 1, CFGT = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start_i = 0, cfg_word_i = 0;
  logic [11:0] word_i = '0;
  logic [15:0] pulse_us_i = 16'd10, max_tries_i = 16'd8;
  logic [7:0]  over_a_i = 8'd11, over_b_i = 8'd0;
  logic        busy_o, done_o, fail_o, sn, stp, oe;
  logic [15:0] pulses_o;
  logic [11:0] dat_o, dat_i;

  pvs_prog_seq #(.CLK_HZ(CLK_HZ), .CFG_TOTAL_US(CFGT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_i(word_i), .cfg_word_i(cfg_word_i),
    .pulse_us_i(pulse_us_i), .max_tries_i(max_tries_i), .over_a_i(over_a_i), .over_b_i(over_b_i),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o), .pulses_o(pulses_o),
    .tgt_strobe_n_o(sn), .tgt_step_o(stp), .tgt_oe_o(oe), .tgt_dat_o(dat_o), .tgt_dat_i(dat_i)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit wd = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Target model: takes the word after `need` program pulses.
  logic [11:0] exp_word = '0;
  int need = 1, tgt_cnt = 0, pw_cur = 10;
  assign dat_i = (tgt_cnt >= need) ? exp_word : 12'hFFF;

  // Port monitor, sampled on the falling edge.
  int pc_prog = 0, pc_ver = 0, pc_inc = 0;
  int low_len = 0, high_len = 0, oe_len = 0, inc_len = 0;
  bit prev_sn = 1, prev_oe = 0, prev_inc = 0, low_oe = 0, seen_low = 0;
  logic [11:0] low_dat = '0;

  always @(negedge clk) if (rst_n) begin
    if (!sn && prev_sn) begin
      if (seen_low) chk(high_len >= TREC*CPU, "R3 gap", high_len, TREC*CPU);
      seen_low = 1; low_oe = oe; low_dat = dat_o; high_len = 0;
    end
    if (sn && !prev_sn) begin
      if (low_oe) begin
        pc_prog++; tgt_cnt++;
        chk(low_len == pw_cur*CPU, "R2 width", low_len, pw_cur*CPU);
        chk(low_dat == exp_word, "R2/R10 data", int'(low_dat), int'(exp_word));
      end else begin
        pc_ver++;
        chk(low_len == TVER*CPU, "R3 verify width", low_len, TVER*CPU);
      end
    end
    if (prev_oe && !oe) chk(oe_len == (TSU+pw_cur+TH)*CPU, "R2 drive run", oe_len, (TSU+pw_cur+TH)*CPU);
    if (prev_inc && !stp) begin
      pc_inc++;
      chk(inc_len == TINC*CPU, "R8 step width", inc_len, TINC*CPU);
    end
    if (stp && !sn) chk(0, "R8 step with strobe low", 0, 1);
    low_len  = sn ? 0 : low_len + 1;
    if (sn) high_len++;
    oe_len   = oe ? oe_len + 1 : 0;
    inc_len  = stp ? inc_len + 1 : 0;
    prev_sn = sn; prev_oe = oe; prev_inc = stp;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !wd) begin
      wd = 1; fails++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic run_word(input logic [11:0] w, input bit cfg, input int nd, input int pw,
                          input int a, input int b, input int mx, input bit poke);
    int lim, e_prog, e_ver, e_inc, e_n, e_fail, p, t;
    @(negedge clk);
    word_i = w; cfg_word_i = cfg; pulse_us_i = 16'(pw); over_a_i = 8'(a); over_b_i = 8'(b);
    max_tries_i = 16'(mx);
    exp_word = w; need = nd; pw_cur = pw; tgt_cnt = 0; pc_prog = 0; pc_ver = 0; pc_inc = 0;
    start_i = 1;
    @(negedge clk); start_i = 0;
    chk(busy_o == 1'b1, "R11 busy after start", busy_o, 1);
    t = 0;
    while (!done_o && t < 20000) begin
      @(negedge clk); t++;
      if (poke && t == 30) begin start_i = 1; word_i = ~w; end
      if (poke && t == 31) begin start_i = 0; word_i = w; end
    end
    chk(t < 20000, "R11 job ends", t, 20000);
    lim = (mx == 0) ? 1 : mx;
    if (cfg) begin
      p = (CFGT + pw - 1) / pw;
      e_prog = p; e_ver = 1; e_n = p; e_fail = (nd > p); e_inc = !e_fail;
    end else if (nd <= lim) begin
      e_prog = nd + a*nd + b; e_ver = nd; e_inc = 1; e_n = nd; e_fail = 0;
    end else begin
      e_prog = lim; e_ver = lim; e_inc = 0; e_n = lim; e_fail = 1;
    end
    chk(pc_prog == e_prog, cfg ? "R9 pulses" : "R7 program pulses", pc_prog, e_prog);
    chk(pc_ver == e_ver, cfg ? "R9 verifies" : "R4 verifies", pc_ver, e_ver);
    chk(pc_inc == e_inc, "R8 steps", pc_inc, e_inc);
    chk(int'(pulses_o) == e_n, e_fail ? "R5 count" : "R4 count", pulses_o, e_n);
    chk(int'(fail_o) == e_fail, (nd == lim) ? "R6 pass at limit" : "R5 fail flag", fail_o, e_fail);
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R11 done pulse", done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sn == 1 && stp == 0 && oe == 0 && busy_o == 0 && done_o == 0 && fail_o == 0,
        "R1 in reset", {sn, stp, oe, busy_o, done_o, fail_o}, 6'b100000);
    rst_n = 1;
    @(negedge clk);
    chk(sn == 1 && stp == 0 && oe == 0 && busy_o == 0 && done_o == 0 && fail_o == 0,
        "R1 after reset", {sn, stp, oe, busy_o, done_o, fail_o}, 6'b100000);
    // R4 R6 R5: sweep the acceptance point across and past the limit of 8.
    for (int k = 1; k <= 9; k++) run_word(12'(12'h5A0 + k), 0, k, 10, 11, 0, 8, 0);
    // R7: other coefficients, limit 4.
    for (int k = 1; k <= 5; k++) run_word(12'(12'h301 * k), 0, k, 10, 2, 3, 4, 0);
    run_word(12'hA93, 0, 2, 10, 0, 0, 8, 0);   // R7 zero margin
    run_word(12'h0C4, 0, 2, 100, 1, 0, 8, 0);  // R2 long pulse
    run_word(12'hFFF & 12'h7E1, 1, 5, 10, 11, 0, 8, 0);  // R9 pass, 20 pulses
    run_word(12'h00D, 1, 7, 30, 11, 0, 8, 0);  // R9 pass, 7 pulses
    run_word(12'h00E, 1, 8, 30, 11, 0, 8, 0);  // R9 fail
    run_word(12'h123, 0, 3, 10, 1, 0, 8, 1);   // R10 start during job
    run_word(12'h456, 0, 2, 10, 1, 0, 0, 0);   // R5 limit 0 acts as 1
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule